// File: doc/BRIEF.md
# SMBus Target Transaction Header Builder

This block sits beside the byte-level engine of an SMBus target and watches one bus transaction from start condition to stop condition. It counts the write data bytes that the target acknowledged and the bytes the target supplied to the master during reads. It also works out what kind of transaction took place: a plain SMBus/I2C access, a block read from the general-purpose read buffer, one of the ARP commands, or a notify message. Every accepted write data byte is handed on through a one-cycle push strobe, so a downstream buffer or DMA engine can store the payload.

When the stop condition arrives, the block packs the counts and the message type into a 32-bit status header. The header is presented with a valid strobe that lasts one clock. A repeated start does not close the transaction, and a NACKed write byte truncates the payload for the rest of the transaction. The ARP device address, the notify address and the general-purpose read command are parameters.

Top module: `smbus_hdr_builder`

## Requirements
- R1: One cycle after a stop condition is seen inside a transaction, `hdr_valid` is high for exactly one clock. `hdr_data` then holds the payload count in bits 31:24, zero in 23:22, the read count in 21:16, zero in 15:12, the message type in 11:8 and zero in 7:0.
- R2: Each write data byte the target acknowledges (`ev_wr` with `wr_ack`=1) adds one to the payload count and is pushed one cycle later on `pay_push`/`pay_data`. Address bytes are neither counted nor pushed. A count of zero means no payload.
- R3: After the first write byte with `wr_ack`=0, neither that byte nor any later write byte of the same transaction is counted or pushed.
- R4: Every `ev_rd` pulse adds one to the read count. This includes the byte-count byte, the PEC byte and a final byte the master NACKs. Read bytes are never pushed. The read count is zero for a transaction with no `ev_rd`.
- R5: The payload count saturates at 255 and the read count at 63. Bytes accepted after saturation are still pushed.
- R6: When the first address is the ARP address 0x61, the first accepted write byte selects the type: 0x01 gives 1000, 0x02 gives 1001, 0x03 gives 1010 and 0x04 gives 1011. Any other command gives 1101 when its bit 0 is 0 and 1100 when its bit 0 is 1.
- R7: When the first address is 0x08 with the write direction (address byte bit 0 = 0), the type is 1111.
- R8: For any other address, the type is 0111 when the transaction contains a read-direction address byte and its first accepted write byte equals the general-purpose command (0x20). Otherwise the type is 0000.
- R9: When a stop arrives before classification is complete, the type is the reserved value 1110. This happens when no address byte was seen, or when the ARP address was seen with no accepted command byte.
- R10: A repeated start keeps the counters and the classification of the running transaction. The first address byte of the transaction is the one that is decoded. Byte events and stop outside a transaction are ignored, and a stop outside a transaction produces no header.
- R11: After reset, `hdr_valid` and `pay_push` are low.
- R12: A write byte or read byte arriving in the same cycle as the stop is included in the header. An accepted write byte in that cycle is pushed in the same cycle as `hdr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop condition seen |
| ev_addr | input | 1 | Address byte received |
| addr_byte | input | 8 | Address byte: 7-bit address in 7:1, read direction in bit 0 |
| ev_wr | input | 1 | Write data byte received from the master |
| wr_ack | input | 1 | Target acknowledged the write byte |
| wr_byte | input | 8 | Write data byte value |
| ev_rd | input | 1 | Target-supplied byte transferred to the master |
| hdr_valid | output | 1 | Header strobe, one clock |
| hdr_data | output | 32 | Packed status header |
| pay_push | output | 1 | Payload byte strobe |
| pay_data | output | 8 | Payload byte |

## Verification
The last write byte and the stop condition can share a cycle. When they do, the payload push and the header strobe leave the block together, and the header must already count that byte. The bench drives a write byte together with `ev_stop` in one cycle, and also a read byte together with the stop. A behavioural reference model, updated on every clock edge, decides whether the push and the header appear in the same cycle and what the header fields hold. The header must include the final byte in both cases.

// File: rtl/smbus_hdr_pkg.sv
package smbus_hdr_pkg;

   typedef enum logic [3:0] {
      MT_GENERIC    = 4'h0,
      MT_GPREAD     = 4'h7,
      MT_ARP_PREP   = 4'h8,
      MT_ARP_RST_G  = 4'h9,
      MT_ARP_UDID_G = 4'hA,
      MT_ARP_ASSIGN = 4'hB,
      MT_ARP_UDID_D = 4'hC,
      MT_ARP_RST_D  = 4'hD,
      MT_UNCLASS    = 4'hE,
      MT_NOTIFY     = 4'hF
   } msg_type_e;

   localparam int HDR_PAY_W = 8;
   localparam int HDR_RD_W  = 6;

   function automatic logic [31:0] pack_hdr(input logic [HDR_PAY_W-1:0] pay,
                                            input logic [HDR_RD_W-1:0]  rd,
                                            input msg_type_e             mt);
      return {pay, 2'b00, rd, 4'h0, mt, 8'h00};
   endfunction

endpackage

// File: rtl/smbus_hdr_satcnt.sv
module smbus_hdr_satcnt #(
   parameter int W        = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cnt_nxt
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   generate
      if (W < 1) begin : g_bad_w
         $error("smbus_hdr_satcnt: W must be at least 1");
      end
      if (SATURATE) begin : g_sat
         always_comb cnt_nxt = (inc && (cnt != MAXV)) ? cnt + W'(1) : cnt;

         assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == MAXV && inc && !clr) |=> (cnt == MAXV));
      end else begin : g_wrap
         always_comb cnt_nxt = cnt + W'(inc);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt_nxt;
   end

endmodule

// File: rtl/smbus_hdr_class.sv
module smbus_hdr_class
   import smbus_hdr_pkg::*;
#(
   parameter int                ADDR_W      = 7,
   parameter logic [ADDR_W-1:0] ARP_ADDR    = 7'h61,
   parameter logic [ADDR_W-1:0] NOTIFY_ADDR = 7'h08,
   parameter logic [7:0]        GP_CMD      = 8'h20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            addr_ev,
   input  logic [ADDR_W:0] addr_byte,
   input  logic            cmd_ev,
   input  logic [7:0]      cmd_byte,
   input  logic            clr,
   output msg_type_e       mtype
);
   logic              got_addr, got_addr_n;
   logic [ADDR_W-1:0] faddr, faddr_n;
   logic              frw, frw_n;
   logic              saw_rd, saw_rd_n;
   logic              got_cmd, got_cmd_n;
   logic [7:0]        cmd, cmd_n;

   always_comb begin
      got_addr_n = got_addr | addr_ev;
      faddr_n    = got_addr ? faddr : (addr_ev ? addr_byte[ADDR_W:1] : faddr);
      frw_n      = got_addr ? frw   : (addr_ev ? addr_byte[0] : frw);
      saw_rd_n   = saw_rd | (addr_ev & addr_byte[0]);
      got_cmd_n  = got_cmd | cmd_ev;
      cmd_n      = got_cmd ? cmd : (cmd_ev ? cmd_byte : cmd);
   end

   function automatic msg_type_e arp_decode(input logic [7:0] c);
      case (c)
         8'h01:   return MT_ARP_PREP;
         8'h02:   return MT_ARP_RST_G;
         8'h03:   return MT_ARP_UDID_G;
         8'h04:   return MT_ARP_ASSIGN;
         default: return c[0] ? MT_ARP_UDID_D : MT_ARP_RST_D;
      endcase
   endfunction

   always_comb begin
      if (!got_addr_n)
         mtype = MT_UNCLASS;
      else if (faddr_n == ARP_ADDR)
         mtype = got_cmd_n ? arp_decode(cmd_n) : MT_UNCLASS;
      else if (faddr_n == NOTIFY_ADDR && !frw_n)
         mtype = MT_NOTIFY;
      else if (saw_rd_n && got_cmd_n && cmd_n == GP_CMD)
         mtype = MT_GPREAD;
      else
         mtype = MT_GENERIC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         got_addr <= 1'b0;
         faddr    <= '0;
         frw      <= 1'b0;
         saw_rd   <= 1'b0;
         got_cmd  <= 1'b0;
         cmd      <= '0;
      end else if (clr) begin
         got_addr <= 1'b0;
         faddr    <= '0;
         frw      <= 1'b0;
         saw_rd   <= 1'b0;
         got_cmd  <= 1'b0;
         cmd      <= '0;
      end else begin
         got_addr <= got_addr_n;
         faddr    <= faddr_n;
         frw      <= frw_n;
         saw_rd   <= saw_rd_n;
         got_cmd  <= got_cmd_n;
         cmd      <= cmd_n;
      end
   end

   assert_first_addr_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (got_addr && addr_ev && !clr) |=> (faddr == $past(faddr)));

   assert_first_cmd_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (got_cmd && cmd_ev && !clr) |=> (cmd == $past(cmd)));

endmodule

// File: rtl/smbus_hdr_builder.sv
module smbus_hdr_builder
   import smbus_hdr_pkg::*;
#(
   parameter int         PAY_W       = 8,
   parameter int         RD_W        = 6,
   parameter bit         SATURATE    = 1'b1,
   parameter logic [6:0] ARP_ADDR    = 7'h61,
   parameter logic [6:0] NOTIFY_ADDR = 7'h08,
   parameter logic [7:0] GP_CMD      = 8'h20
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ev_start,
   input  logic        ev_stop,
   input  logic        ev_addr,
   input  logic [7:0]  addr_byte,
   input  logic        ev_wr,
   input  logic        wr_ack,
   input  logic [7:0]  wr_byte,
   input  logic        ev_rd,
   output logic        hdr_valid,
   output logic [31:0] hdr_data,
   output logic        pay_push,
   output logic [7:0]  pay_data
);
   generate
      if (PAY_W != HDR_PAY_W) begin : g_bad_pay
         $error("smbus_hdr_builder: PAY_W must match the 8-bit header field");
      end
      if (RD_W != HDR_RD_W) begin : g_bad_rd
         $error("smbus_hdr_builder: RD_W must match the 6-bit header field");
      end
   endgenerate

   logic             in_txn;
   logic             trunc_q;
   logic             stop_ok, wr_take, rd_take, addr_take;
   logic [PAY_W-1:0] pay_cnt, pay_cnt_nxt;
   logic [RD_W-1:0]  rd_cnt, rd_cnt_nxt;
   msg_type_e        mtype;

   assign stop_ok   = ev_stop & in_txn;
   assign addr_take = ev_addr & in_txn;
   assign wr_take   = ev_wr & in_txn & wr_ack & ~trunc_q;
   assign rd_take   = ev_rd & in_txn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_txn  <= 1'b0;
         trunc_q <= 1'b0;
      end else if (stop_ok) begin
         in_txn  <= 1'b0;
         trunc_q <= 1'b0;
      end else begin
         if (ev_start) in_txn <= 1'b1;
         if (ev_wr && in_txn && !wr_ack) trunc_q <= 1'b1;
      end
   end

   smbus_hdr_satcnt #(.W(PAY_W), .SATURATE(SATURATE)) u_pay_cnt (
      .clk(clk), .rst_n(rst_n), .inc(wr_take), .clr(stop_ok),
      .cnt(pay_cnt), .cnt_nxt(pay_cnt_nxt));

   smbus_hdr_satcnt #(.W(RD_W), .SATURATE(SATURATE)) u_rd_cnt (
      .clk(clk), .rst_n(rst_n), .inc(rd_take), .clr(stop_ok),
      .cnt(rd_cnt), .cnt_nxt(rd_cnt_nxt));

   smbus_hdr_class #(.ADDR_W(7), .ARP_ADDR(ARP_ADDR), .NOTIFY_ADDR(NOTIFY_ADDR),
                     .GP_CMD(GP_CMD)) u_class (
      .clk(clk), .rst_n(rst_n), .addr_ev(addr_take), .addr_byte(addr_byte),
      .cmd_ev(wr_take), .cmd_byte(wr_byte), .clr(stop_ok), .mtype(mtype));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_valid <= 1'b0;
         hdr_data  <= '0;
         pay_push  <= 1'b0;
         pay_data  <= '0;
      end else begin
         hdr_valid <= stop_ok;
         if (stop_ok) hdr_data <= pack_hdr(pay_cnt_nxt, rd_cnt_nxt, mtype);
         pay_push  <= wr_take;
         if (wr_take) pay_data <= wr_byte;
      end
   end

   assert_hdr_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> !hdr_valid);

   assert_hdr_after_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |-> $past(ev_stop));

   assert_push_from_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pay_push |-> $past(ev_wr && wr_ack));

   assert_no_push_after_nack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (trunc_q && !stop_ok && ev_wr) |=> !pay_push);

   assert_no_read_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && !ev_wr) |=> !pay_push);

endmodule

// File: tb/smbus_hdr_builder_bench.sv
module smbus_hdr_builder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_start = 0, ev_stop = 0, ev_addr = 0, ev_wr = 0, wr_ack = 0, ev_rd = 0;
   logic [7:0]  addr_byte = 0, wr_byte = 0;
   logic        hdr_valid, pay_push;
   logic [31:0] hdr_data;
   logic [7:0]  pay_data;

   always #5 clk = ~clk;

   smbus_hdr_builder u_smbus_hdr_builder (
      .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_addr(ev_addr), .addr_byte(addr_byte), .ev_wr(ev_wr), .wr_ack(wr_ack),
      .wr_byte(wr_byte), .ev_rd(ev_rd), .hdr_valid(hdr_valid), .hdr_data(hdr_data),
      .pay_push(pay_push), .pay_data(pay_data));

   int    checks = 0, failures = 0;
   string cur_req = "R11";
   bit    done = 0;

   // behavioural reference model
   bit          m_in, m_trunc, m_ga, m_frw, m_srd, m_gc;
   int          m_fa, m_cmd, m_rd;
   logic [7:0]  m_q[$];
   bit          e_push, e_hv;
   logic [7:0]  e_pd;
   logic [31:0] e_hd;

   function automatic logic [3:0] model_type();
      if (!m_ga) return 4'hE;
      if (m_fa == 'h61) begin
         if (!m_gc) return 4'hE;
         case (m_cmd)
            1: return 4'h8;
            2: return 4'h9;
            3: return 4'hA;
            4: return 4'hB;
            default: return (m_cmd % 2) ? 4'hC : 4'hD;
         endcase
      end
      if (m_fa == 'h08 && !m_frw) return 4'hF;
      if (m_srd && m_gc && m_cmd == 'h20) return 4'h7;
      return 4'h0;
   endfunction

   task automatic model_clear();
      m_in = 0; m_trunc = 0; m_ga = 0; m_frw = 0; m_srd = 0; m_gc = 0;
      m_fa = 0; m_cmd = 0; m_rd = 0; m_q.delete();
   endtask

   always @(posedge clk) begin
      e_push = 0;
      e_hv   = 0;
      if (!rst_n) begin
         model_clear();
      end else if (m_in) begin
         if (ev_addr) begin
            if (!m_ga) begin m_ga = 1; m_fa = int'(addr_byte) / 2; m_frw = addr_byte[0]; end
            if (addr_byte[0]) m_srd = 1;
         end
         if (ev_wr) begin
            if (!wr_ack) m_trunc = 1;
            else if (!m_trunc) begin
               m_q.push_back(wr_byte);
               e_push = 1; e_pd = wr_byte;
               if (!m_gc) begin m_gc = 1; m_cmd = int'(wr_byte); end
            end
         end
         if (ev_rd) m_rd++;
         if (ev_stop) begin
            int p, r;
            p = (m_q.size() > 255) ? 255 : m_q.size();
            r = (m_rd > 63) ? 63 : m_rd;
            e_hv = 1;
            e_hd = {p[7:0], 2'b00, r[5:0], 4'h0, model_type(), 8'h00};
            model_clear();
         end
      end else if (ev_start) begin
         m_in = 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (pay_push !== e_push || (e_push && pay_data !== e_pd) ||
             hdr_valid !== e_hv || (e_hv && hdr_data !== e_hd)) begin
            failures++;
            $display("FAIL %s push=%b/%b pdata=%h/%h hv=%b/%b hdr=%h/%h", cur_req,
                     pay_push, e_push, pay_data, e_pd, hdr_valid, e_hv, hdr_data, e_hd);
         end
      end
   end

   task automatic ev(input bit s, input bit p, input bit a, input logic [7:0] ab,
                     input bit w, input bit k, input logic [7:0] wb, input bit r);
      @(negedge clk);
      ev_start = s; ev_stop = p; ev_addr = a; addr_byte = ab;
      ev_wr = w; wr_ack = k; wr_byte = wb; ev_rd = r;
   endtask

   task automatic t_idle();                               ev(0,0,0,0,0,0,0,0); endtask
   task automatic t_start();                              ev(1,0,0,0,0,0,0,0); endtask
   task automatic t_stop();                               ev(0,1,0,0,0,0,0,0); endtask
   task automatic t_addr(input logic [6:0] a, input bit rw); ev(0,0,1,{a,rw},0,0,0,0); endtask
   task automatic t_wr(input logic [7:0] b, input bit k); ev(0,0,0,0,1,k,b,0); endtask
   task automatic t_rd();                                 ev(0,0,0,0,0,0,0,1); endtask

   task automatic arp_write(input logic [7:0] c);
      t_start(); t_addr(7'h61, 0); t_wr(c, 1); t_wr(8'h5A, 1); t_stop(); t_idle();
   endtask

   task automatic finish_run();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      checks++;
      if (hdr_valid !== 1'b0 || pay_push !== 1'b0) begin
         failures++;
         $display("FAIL R11 hv=%b push=%b expected 0 0", hdr_valid, pay_push);
      end
      rst_n = 1'b1;
      t_idle(); t_idle();

      cur_req = "R10";   // ignored outside a transaction
      t_wr(8'h11, 1); t_rd(); t_stop(); t_idle();

      cur_req = "R2";    // plain write, generic type
      t_start(); t_addr(7'h50, 0); t_wr(8'h10, 1); t_wr(8'hA1, 1); t_wr(8'hB2, 1); t_stop(); t_idle();

      cur_req = "R3";    // NACK truncates payload
      t_start(); t_addr(7'h50, 0); t_wr(8'h01, 1); t_wr(8'h02, 1); t_wr(8'h03, 1);
      t_wr(8'h04, 0); t_wr(8'h05, 1); t_wr(8'h06, 1); t_stop(); t_idle();

      cur_req = "R4";    // block read from general-purpose buffer with repeated start
      t_start(); t_addr(7'h50, 0); t_wr(8'h20, 1); t_start(); t_addr(7'h50, 1);
      repeat (5) t_rd();
      t_stop(); t_idle();

      cur_req = "R8";    // read with other command is generic
      t_start(); t_addr(7'h33, 0); t_wr(8'h21, 1); t_start(); t_addr(7'h33, 1);
      t_rd(); t_rd(); t_stop(); t_idle();

      cur_req = "R6";    // ARP commands
      arp_write(8'h01); arp_write(8'h02); arp_write(8'h04);
      arp_write(8'h06); arp_write(8'h07); arp_write(8'hC3);
      t_start(); t_addr(7'h61, 0); t_wr(8'h03, 1); t_start(); t_addr(7'h61, 1);
      repeat (19) t_rd();
      t_stop(); t_idle();

      cur_req = "R7";    // notify
      t_start(); t_addr(7'h08, 0); t_wr(8'h16, 1); t_wr(8'h34, 1); t_wr(8'h12, 1); t_stop(); t_idle();
      t_start(); t_addr(7'h08, 1); t_rd(); t_stop(); t_idle();

      cur_req = "R9";    // unclassified
      t_start(); t_stop(); t_idle();
      t_start(); t_addr(7'h61, 0); t_stop(); t_idle();
      t_start(); t_addr(7'h61, 0); t_wr(8'h02, 0); t_stop(); t_idle();

      cur_req = "R5";    // saturation
      t_start(); t_addr(7'h44, 0);
      for (int i = 0; i < 300; i++) t_wr(8'(i), 1);
      t_start(); t_addr(7'h44, 1);
      for (int i = 0; i < 70; i++) t_rd();
      t_stop(); t_idle();

      cur_req = "R12";   // last byte in the stop cycle
      t_start(); t_addr(7'h50, 0); t_wr(8'h77, 1);
      ev(0,1,0,0,1,1,8'h99,0); t_idle();
      t_start(); t_addr(7'h50, 1); t_rd();
      ev(0,1,0,0,0,0,0,1); t_idle();

      cur_req = "R1";    // back-to-back transactions
      t_start(); t_addr(7'h2A, 0); t_wr(8'h0F, 1); t_stop();
      t_start(); t_addr(7'h2A, 0); t_stop(); t_idle(); t_idle();

      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

endmodule